// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregation Controller

This block funnels many small interrupt causes into a single external interrupt line. The causes are two groups of seven link-layer events (one group per network port), twelve general-purpose input lines, and a down-counting timer that raises an event each time it rolls under from zero to all ones. Every cause has a sticky flag that software clears by writing a one to it. Every cause also has an individual enable.

The controller gates in three stages. First, per-cause enables reduce each group to a single summary bit in a top-level status word. Second, a top-level enable word selects which summary bits may interrupt. Third, a global output enable in a configuration word decides whether the pin moves at all. The pin is registered and its active level is programmable.

Software reaches every register through a flat word-addressed write strobe and a combinational read port. Register addresses are listed in R10.

Top module: `irq_hub`

## Requirements
- R1: A rising edge on any event input sets its sticky flag at the next clock edge. The flag stays set after the input falls. An input held high does not set the flag again once it has been cleared.
- R2: Writing a word to a flag register clears exactly the flags whose written bit is 1. If an event edge and its clear arrive in the same cycle, the flag stays set.
- R3: In the status word, bit 26 reads as the OR of port-1 flags AND port-1 enables, and bit 27 does the same for port 2. Bit 12 reads as the OR of the GPIO flags AND the GPIO enables. Writes to these three bits have no effect.
- R4: The top enable word stores only bits 26, 27, 12 and 19. All other bits read as 0.
- R5: The interrupt is active only when a status bit and its matching top enable bit are both set, and IRQ enable (config bit 8) is also set. The pin follows these conditions one clock later.
- R6: Config bit 4 selects the pin polarity: 1 means active high, 0 means active low. The inactive level is the opposite of the active level.
- R7: Timer configuration holds the reload value in bits 15:0 and the run bit at bit 29. When the run bit rises, the count loads the reload value. While running, the count decrements once every PRESCALE cycles. While stopped, the count holds.
- R8: When the count steps below zero it becomes FFFFh and sets status bit 19. Writing 1 to status bit 19 clears it.
- R9: After reset, all flags, enables, the timer and the status word are 0. Config reads as 10h (active high, output disabled), and the pin is low.
- R10: Word addresses: 0 status, 1 top enable, 2 config, 3 port-1 flags, 4 port-1 enables, 5 port-2 flags, 6 port-2 enables, 7 GPIO (flags in bits 11:0, enables in bits 27:16), 8 timer config, 9 timer count (read-only). Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phy1_evt | input | PHY_EVTS | Port-1 link event inputs |
| phy2_evt | input | PHY_EVTS | Port-2 link event inputs |
| gpio_evt | input | GPIO_LINES | General-purpose event inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq_out | output | 1 | Registered interrupt pin |

## Verification
Every single event bit on both ports and every GPIO line is pulsed in turn. The bench then checks the flag, the summary bit with its enable off and on, and the write-one clear. This separates a wrong bit position from wrong gating.

The gate sweep covers all sixteen combinations of pending cause, top enable, output enable and polarity. Only the one combination with all three gates open may drive the active level, so any missing gate or inverted polarity shows up.

The timer runs from a small reload value, and the count is sampled at the exact prescaled steps and at the wrap. Separate patterns cover a level held high, a clear that coincides with an edge, and writes to read-only summary bits.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int TMR_W  = 16;

    // fixed bit positions
    localparam int BIT_PHY1   = 26;
    localparam int BIT_PHY2   = 27;
    localparam int BIT_GPIO   = 12;
    localparam int BIT_TMR    = 19;
    localparam int BIT_IRQEN  = 8;
    localparam int BIT_POL    = 4;
    localparam int BIT_TMREN  = 29;
    localparam int GPIO_EN_LO = 16;

    localparam logic [ADDR_W-1:0] A_STS   = 4'd0;
    localparam logic [ADDR_W-1:0] A_TOPEN = 4'd1;
    localparam logic [ADDR_W-1:0] A_CFG   = 4'd2;
    localparam logic [ADDR_W-1:0] A_P1FLG = 4'd3;
    localparam logic [ADDR_W-1:0] A_P1EN  = 4'd4;
    localparam logic [ADDR_W-1:0] A_P2FLG = 4'd5;
    localparam logic [ADDR_W-1:0] A_P2EN  = 4'd6;
    localparam logic [ADDR_W-1:0] A_GPIO  = 4'd7;
    localparam logic [ADDR_W-1:0] A_TCFG  = 4'd8;
    localparam logic [ADDR_W-1:0] A_TCNT  = 4'd9;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         clr_i,
    input  logic [W-1:0] clr_bits_i,
    output logic [W-1:0] flags_o
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] flags;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [W-1:0] rise;
    logic [W-1:0] wipe;

    always_comb begin
        rise       = evt_i & ~st_q.prev;
        wipe       = clr_i ? clr_bits_i : '0;
        st_d.prev  = evt_i;
        // a new edge wins over a clear in the same cycle
        st_d.flags = (st_q.flags & ~wipe) | rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    // R1: an edge always leaves its flag set one cycle later
    p_edge_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_i & ~st_q.prev) != '0) |=>
        ((($past(evt_i) & ~$past(st_q.prev)) & ~flags_o) == '0));

    // R2: a flag only drops when a one was written to it
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(flags_o) & ~($past(clr_i) ? $past(clr_bits_i) : '0))
                   & ~flags_o) == '0));
endmodule

// File: rtl/irq_wrap_timer.sv
module irq_wrap_timer #(
    parameter int CW       = 16,
    parameter int PRESCALE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [CW-1:0] reload_i,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);

    typedef struct packed {
        logic          en_prev;
        logic [PW-1:0] pre;
        logic [CW-1:0] cnt;
        logic          wrap;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.en_prev = en_i;
        st_d.wrap    = 1'b0;
        if (en_i && !st_q.en_prev) begin
            st_d.cnt = reload_i;
            st_d.pre = '0;
        end else if (en_i) begin
            if (st_q.pre == PLAST) begin
                st_d.pre = '0;
                if (st_q.cnt == '0) begin
                    st_d.cnt  = '1;
                    st_d.wrap = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign wrap_o = st_q.wrap;

    // R8: a wrap event always coincides with an all-ones count
    p_wrap_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |-> (cnt_o == '1));

    // R7: a stopped timer holds its count
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(cnt_o));
endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int PHY_EVTS   = 7,
    parameter int GPIO_LINES = 12,
    parameter int PRESCALE   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PHY_EVTS-1:0]   phy1_evt,
    input  logic [PHY_EVTS-1:0]   phy2_evt,
    input  logic [GPIO_LINES-1:0] gpio_evt,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  irq_out
);
    localparam int NPORT = 2;

    typedef struct packed {
        logic [NPORT-1:0][PHY_EVTS-1:0] phy_en;
        logic [GPIO_LINES-1:0]          gpio_en;
        logic                           top_phy1;
        logic                           top_phy2;
        logic                           top_gpio;
        logic                           top_tmr;
        logic                           irq_en;
        logic                           pol;
        logic                           tmr_run;
        logic [TMR_W-1:0]               tmr_reload;
        logic                           tmr_flag;
        logic                           irq;
    } hub_st_t;

    hub_st_t st_d, st_q;

    logic [NPORT-1:0][PHY_EVTS-1:0] phy_evt_w;
    logic [NPORT-1:0][PHY_EVTS-1:0] phy_flags;
    logic [NPORT-1:0]               phy_clr;
    logic [GPIO_LINES-1:0]          gpio_flags;
    logic                           gpio_clr;
    logic [TMR_W-1:0]               tmr_cnt;
    logic                           tmr_wrap;
    logic [DATA_W-1:0]              top_sts;
    logic [DATA_W-1:0]              top_en_vec;
    logic                           pending;

    assign phy_evt_w[0] = phy1_evt;
    assign phy_evt_w[1] = phy2_evt;
    assign phy_clr[0]   = reg_wr && (reg_addr == A_P1FLG);
    assign phy_clr[1]   = reg_wr && (reg_addr == A_P2FLG);
    assign gpio_clr     = reg_wr && (reg_addr == A_GPIO);

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        irq_flag_bank #(.W(PHY_EVTS)) u_phy_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt_i      (phy_evt_w[p]),
            .clr_i      (phy_clr[p]),
            .clr_bits_i (reg_wdata[PHY_EVTS-1:0]),
            .flags_o    (phy_flags[p])
        );
    end

    irq_flag_bank #(.W(GPIO_LINES)) u_gpio_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (gpio_evt),
        .clr_i      (gpio_clr),
        .clr_bits_i (reg_wdata[GPIO_LINES-1:0]),
        .flags_o    (gpio_flags)
    );

    irq_wrap_timer #(.CW(TMR_W), .PRESCALE(PRESCALE)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (st_q.tmr_run),
        .reload_i (st_q.tmr_reload),
        .cnt_o    (tmr_cnt),
        .wrap_o   (tmr_wrap)
    );

    always_comb begin
        top_sts             = '0;
        top_sts[BIT_PHY1]   = |(phy_flags[0] & st_q.phy_en[0]);
        top_sts[BIT_PHY2]   = |(phy_flags[1] & st_q.phy_en[1]);
        top_sts[BIT_GPIO]   = |(gpio_flags & st_q.gpio_en);
        top_sts[BIT_TMR]    = st_q.tmr_flag;
        top_en_vec           = '0;
        top_en_vec[BIT_PHY1] = st_q.top_phy1;
        top_en_vec[BIT_PHY2] = st_q.top_phy2;
        top_en_vec[BIT_GPIO] = st_q.top_gpio;
        top_en_vec[BIT_TMR]  = st_q.top_tmr;
        pending              = st_q.irq_en && ((top_sts & top_en_vec) != '0);
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            unique case (reg_addr)
                A_STS:   if (reg_wdata[BIT_TMR]) st_d.tmr_flag = 1'b0;
                A_TOPEN: begin
                    st_d.top_phy1 = reg_wdata[BIT_PHY1];
                    st_d.top_phy2 = reg_wdata[BIT_PHY2];
                    st_d.top_gpio = reg_wdata[BIT_GPIO];
                    st_d.top_tmr  = reg_wdata[BIT_TMR];
                end
                A_CFG: begin
                    st_d.irq_en = reg_wdata[BIT_IRQEN];
                    st_d.pol    = reg_wdata[BIT_POL];
                end
                A_P1EN:  st_d.phy_en[0] = reg_wdata[PHY_EVTS-1:0];
                A_P2EN:  st_d.phy_en[1] = reg_wdata[PHY_EVTS-1:0];
                A_GPIO:  st_d.gpio_en   = reg_wdata[GPIO_EN_LO +: GPIO_LINES];
                A_TCFG: begin
                    st_d.tmr_run    = reg_wdata[BIT_TMREN];
                    st_d.tmr_reload = reg_wdata[TMR_W-1:0];
                end
                default: ;
            endcase
        end
        if (tmr_wrap) st_d.tmr_flag = 1'b1;
        st_d.irq = pending ? st_q.pol : ~st_q.pol;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.pol <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_STS:   reg_rdata = top_sts;
            A_TOPEN: reg_rdata = top_en_vec;
            A_CFG: begin
                reg_rdata[BIT_IRQEN] = st_q.irq_en;
                reg_rdata[BIT_POL]   = st_q.pol;
            end
            A_P1FLG: reg_rdata[PHY_EVTS-1:0] = phy_flags[0];
            A_P1EN:  reg_rdata[PHY_EVTS-1:0] = st_q.phy_en[0];
            A_P2FLG: reg_rdata[PHY_EVTS-1:0] = phy_flags[1];
            A_P2EN:  reg_rdata[PHY_EVTS-1:0] = st_q.phy_en[1];
            A_GPIO: begin
                reg_rdata[GPIO_LINES-1:0]             = gpio_flags;
                reg_rdata[GPIO_EN_LO +: GPIO_LINES]   = st_q.gpio_en;
            end
            A_TCFG: begin
                reg_rdata[BIT_TMREN]   = st_q.tmr_run;
                reg_rdata[TMR_W-1:0]   = st_q.tmr_reload;
            end
            A_TCNT:  reg_rdata[TMR_W-1:0] = tmr_cnt;
            default: reg_rdata = '0;
        endcase
    end

    assign irq_out = st_q.irq;

    // R5/R6: output disabled means the pin sits at the inactive level
    p_gate_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.irq_en |=> (irq_out == !$past(st_q.pol)));

    // R5/R6: all gates open and a cause pending drives the active level
    p_gate_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq_en && ((top_sts & top_en_vec) != '0)) |=> (irq_out == $past(st_q.pol)));

    // R8: a wrap always leaves the timer status bit set
    p_wrap_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wrap |=> st_q.tmr_flag);
endmodule

// File: tb/irq_hub_tb_top.sv
module irq_hub_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  phy1_evt;
    logic [6:0]  phy2_evt;
    logic [11:0] gpio_evt;
    logic        reg_wr;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    irq_hub #(.PHY_EVTS(7), .GPIO_LINES(12), .PRESCALE(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .phy1_evt(phy1_evt), .phy2_evt(phy2_evt),
        .gpio_evt(gpio_evt), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_evt(input int grp, input int k);
        @(negedge clk);
        if (grp == 0) phy1_evt[k] = 1'b1;
        else if (grp == 1) phy2_evt[k] = 1'b1;
        else gpio_evt[k] = 1'b1;
        @(negedge clk);
        phy1_evt = '0; phy2_evt = '0; gpio_evt = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] v2;
        rst_n = 1'b0; phy1_evt = '0; phy2_evt = '0; gpio_evt = '0;
        reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        rd(4'd0, v); check("R9 status", v, 32'h0);
        rd(4'd2, v); check("R9 config", v, 32'h10);
        rd(4'd9, v); check("R9 count", v, 32'h0);
        check("R9 pin", {31'd0, irq_out}, 32'h0);
        // R10 unmapped
        rd(4'd15, v); check("R10 unmapped", v, 32'h0);

        // R4 top enable storage
        wr(4'd1, 32'hFFFF_FFFF);
        rd(4'd1, v); check("R4 top enable bits", v, 32'h0C08_1000);
        wr(4'd1, 32'h0);

        // R1/R2/R3 sweep over every port event
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 7; k++) begin
                logic [3:0] fa;
                logic [3:0] ea;
                int sb;
                fa = (p == 0) ? 4'd3 : 4'd5;
                ea = (p == 0) ? 4'd4 : 4'd6;
                sb = (p == 0) ? 26 : 27;
                pulse_evt(p, k);
                rd(fa, v); check("R1 port flag", v, 32'h1 << k);
                rd(4'd0, v); check("R3 summary masked", v, 32'h0);
                wr(ea, 32'h1 << k);
                rd(4'd0, v); check("R3 summary enabled", v, 32'h1 << sb);
                wr(4'd0, 32'hFFFF_FFFF);
                rd(4'd0, v); check("R3 summary write ignored", v, 32'h1 << sb);
                wr(fa, ~(32'h1 << k));
                rd(fa, v); check("R2 other bits keep", v, 32'h1 << k);
                wr(fa, 32'h1 << k);
                rd(fa, v); check("R2 clear", v, 32'h0);
                rd(4'd0, v); check("R3 summary after clear", v, 32'h0);
                wr(ea, 32'h0);
            end
        end

        // GPIO sweep, enables in bits 27:16
        for (int k = 0; k < 12; k++) begin
            pulse_evt(2, k);
            rd(4'd7, v); check("R1 gpio flag", v, 32'h1 << k);
            rd(4'd0, v); check("R3 gpio masked", v, 32'h0);
            wr(4'd7, 32'h1 << (k + 16));
            rd(4'd0, v); check("R3 gpio enabled", v, 32'h1000);
            wr(4'd7, (32'h1 << (k + 16)) | (32'h1 << k));
            rd(4'd7, v); check("R2 gpio clear", v, 32'h1 << (k + 16));
            wr(4'd7, 32'h0);
        end

        // R1 level held does not re-set
        @(negedge clk); gpio_evt[3] = 1'b1;
        @(negedge clk);
        wr(4'd7, 32'h8);
        repeat (3) @(negedge clk);
        rd(4'd7, v); check("R1 held level no reset", v, 32'h0);
        gpio_evt = '0;
        @(negedge clk);

        // R2 edge and clear same cycle
        @(negedge clk);
        phy1_evt[2] = 1'b1; reg_wr = 1'b1; reg_addr = 4'd3; reg_wdata = 32'h4;
        @(negedge clk);
        reg_wr = 1'b0; phy1_evt = '0;
        rd(4'd3, v); check("R2 edge beats clear", v, 32'h4);
        wr(4'd3, 32'h7F);

        // R5/R6 gate sweep: cause, top enable, output enable, polarity
        wr(4'd7, 32'h0001_0000);
        for (int pol = 0; pol < 2; pol++)
            for (int src = 0; src < 2; src++)
                for (int ten = 0; ten < 2; ten++)
                    for (int ien = 0; ien < 2; ien++) begin
                        logic act;
                        logic expv;
                        wr(4'd7, 32'h0001_0FFF);
                        if (src == 1) pulse_evt(2, 0);
                        wr(4'd1, ten[0] ? 32'h1000 : 32'h0);
                        wr(4'd2, (ien[0] ? 32'h100 : 32'h0) | (pol[0] ? 32'h10 : 32'h0));
                        @(negedge clk);
                        act  = src[0] & ten[0] & ien[0];
                        expv = pol[0] ? act : ~act;
                        check(pol[0] ? "R5 gate active high" : "R6 gate active low",
                              {31'd0, irq_out}, {31'd0, expv});
                    end
        wr(4'd7, 32'h0000_0FFF);
        wr(4'd1, 32'h0);
        wr(4'd2, 32'h10);

        // R7/R8 timer: reload 2, prescale 4
        wr(4'd8, 32'h2000_0002);
        @(negedge clk);
        rd(4'd9, v); check("R7 load", v, 32'h2);
        repeat (4) @(negedge clk);
        rd(4'd9, v); check("R7 first step", v, 32'h1);
        repeat (4) @(negedge clk);
        rd(4'd9, v); check("R7 second step", v, 32'h0);
        repeat (4) @(negedge clk);
        rd(4'd9, v); check("R8 wrap value", v, 32'hFFFF);
        rd(4'd0, v); check("R8 flag not yet", v, 32'h0);
        @(negedge clk);
        rd(4'd0, v); check("R8 flag set", v, 32'h0008_0000);
        wr(4'd8, 32'h0000_0002);
        rd(4'd9, v);
        repeat (10) @(negedge clk);
        rd(4'd9, v2); check("R7 hold when stopped", v2, v);
        wr(4'd1, 32'h0008_0000);
        wr(4'd2, 32'h110);
        @(negedge clk);
        check("R5 timer irq", {31'd0, irq_out}, 32'h1);
        wr(4'd0, 32'h0008_0000);
        rd(4'd0, v); check("R8 clear", v, 32'h0);
        @(negedge clk);
        check("R5 timer irq gone", {31'd0, irq_out}, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule